// File: doc/BRIEF.md
# Serial-Fed One-Bit Audio DAC

This block turns a stream of 8-bit PCM audio bytes, sent by a host over an asynchronous serial line, into a single-bit pulse-density output. An external RC low-pass filter smooths that output into an analog signal. A byte received with a valid stop bit replaces the value the modulator works on. Nothing is queued, and the sample rate is not converted.

A first-order sigma-delta modulator runs at the full system clock. On every cycle it adds the held sample to an accumulator as wide as the sample, and the output pin carries the carry-out of that addition. The sample rate is roughly 11 kHz and the clock runs in the megahertz range, so each sample is held for thousands of modulator cycles. Over time the density of ones tracks the sample value.

The receiver brings the line in through a two-flop synchronizer. It oversamples the line 16 times per bit and confirms the start bit at its midpoint. It accepts 8N1 frames with the data sent least significant bit first. The per-tick clock divisor comes from the clock-frequency and baud-rate parameters when the design is elaborated.

Top module: `sd_audio_dac`

## Requirements
- R1: After reset, `dac_out` and `sample_stb` are low. The accumulator and the held sample are zero, so `dac_out` stays low until the first valid byte arrives.
- R2: A frame made of a low start bit, eight data bits sent least significant bit first and a high stop bit produces exactly one single-cycle `sample_stb` pulse. The byte value becomes the held sample on the same clock edge that raises the pulse.
- R3: While a sample S is held, every window of 256 consecutive `dac_out` cycles contains exactly S ones. The window may start at the second clock edge after the `sample_stb` pulse or at any later edge.
- R4: `dac_out` is the carry of the accumulator addition. A held sample of 0 keeps the output at a constant 0, and a held sample of 255 gives 255 ones in every 256 cycles.
- R5: A frame whose stop bit is sampled low is a framing error. It raises no `sample_stb` and leaves the held sample, and therefore the output density, unchanged.
- R6: A low pulse on the serial line shorter than half a bit period is rejected as a false start. It raises no `sample_stb` and leaves the held sample unchanged.
- R7: Each new valid byte directly replaces the previous sample, whatever its value. Successive bytes each set the output density to their own value.
- R8: One bit period lasts 16 oversampling ticks. The clock cycles per tick are CLK_HZ / (BAUD * 16), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the modulator advances once per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| dac_out | output | 1 | Pulse-density output, the accumulator carry |
| sample_stb | output | 1 | One-cycle pulse when a valid byte loads the held sample |

## Verification
Several rules are checked by assertions on every cycle:
- the strobe never lasts more than one cycle;
- the held sample changes only on a strobe edge;
- a strobe only follows a high stop-bit sample;
- a zero sample forces the output low on the next cycle.

Other behaviour can only be shown by the bench scenarios: exact ones counts over 256-cycle windows, LSB-first byte assembly, and rejection of framing errors and short start glitches. The bench ties each received byte to the output by measuring the pulse density that follows it.

// File: rtl/sd_audio_dac.sv
module sd_audio_dac #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int OVS    = 16,
  parameter int DW     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic dac_out,
  output logic sample_stb
);

  localparam int DIV_RAW = CLK_HZ / (BAUD * OVS);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int DIV_W   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int OS_W    = $clog2(OVS);
  localparam int BIT_W   = $clog2(DW);
  localparam logic [OS_W-1:0]  OS_HALF = OS_W'(OVS / 2 - 1);
  localparam logic [OS_W-1:0]  OS_LAST = OS_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DW - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_st_t;

  logic rx_m, rx_s, rx_d;
  rx_st_t st_q;
  logic [DIV_W-1:0] div_q;
  logic [OS_W-1:0]  os_q;
  logic [BIT_W-1:0] bit_q;
  logic [DW-1:0]    shift_q, sample_q, acc_q;
  logic [DW:0]      sum;
  logic tick, fall;

  assign tick = (div_q == DIV_LAST);
  assign fall = rx_d & ~rx_s;
  assign sum  = {1'b0, acc_q} + {1'b0, sample_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_m <= rx_line;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st_q == ST_IDLE || tick) div_q <= '0;
    else                                   div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      os_q       <= '0;
      bit_q      <= '0;
      shift_q    <= '0;
      sample_q   <= '0;
      sample_stb <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          os_q  <= '0;
          bit_q <= '0;
          if (fall) st_q <= ST_START;
        end
        ST_START: if (tick) begin
          if (os_q == OS_HALF) begin
            os_q <= '0;
            st_q <= rx_s ? ST_IDLE : ST_DATA;
          end else os_q <= os_q + 1'b1;
        end
        ST_DATA: if (tick) begin
          if (os_q == OS_LAST) begin
            os_q    <= '0;
            shift_q <= {rx_s, shift_q[DW-1:1]};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == BIT_LAST) st_q <= ST_STOP;
          end else os_q <= os_q + 1'b1;
        end
        ST_STOP: if (tick) begin
          if (os_q == OS_LAST) begin
            st_q <= ST_IDLE;
            if (rx_s) begin
              sample_q   <= shift_q;
              sample_stb <= 1'b1;
            end
          end else os_q <= os_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      dac_out <= 1'b0;
    end else begin
      acc_q   <= sum[DW-1:0];
      dac_out <= sum[DW];
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);                                 // R2
  AST_SAMPLE_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_q != $past(sample_q)) |-> sample_stb);               // R7
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(rx_s));                                 // R5
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_q == '0) |=> !dac_out);                              // R4
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (os_q == '0 || $past(st_q) != ST_IDLE)); // R8

endmodule

// File: tb/sd_audio_dac_tb_top.sv
`timescale 1ns/1ps
module sd_audio_dac_tb_top;
  localparam int CLK_HZ = 16_000_000;
  localparam int BAUD   = 1_000_000;
  localparam int BIT    = 16;

  typedef struct { int val; string tag; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic dac_out, sample_stb;

  int checks = 0, failures = 0;
  int strobes = 0;
  bit mon_busy = 1'b0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  sd_audio_dac #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(16), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .dac_out(dac_out), .sample_stb(sample_stb));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_bit);
    @(negedge clk) rx_line = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx_line = stop_bit;
    repeat (BIT) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic send_good(input logic [7:0] b, input string tag);
    exp_t e;
    int target;
    e.val = b;
    e.tag = tag;
    target = strobes + 1;
    exp_q.push_back(e);
    send_frame(b, 1'b1);
    wait (strobes >= target && !mon_busy);
    @(negedge clk);
  endtask

  task automatic measure(output int ones);
    ones = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ones += int'(dac_out);
    end
  endtask

  initial begin : monitor
    exp_t e;
    int ones;
    forever begin
      @(negedge clk);
      if (rst_n && sample_stb) begin
        strobes++;
        mon_busy = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected strobe", 1, 0);
        end else begin
          e = exp_q.pop_front();
          ones = 0;
          for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (i == 0) check(!sample_stb, "R2 strobe width", int'(sample_stb), 0);
            ones += int'(dac_out);
          end
          check(ones == e.val, e.tag, ones, e.val);
        end
        mon_busy = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    int ones, s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dac_out == 1'b0, "R1 dac after reset", int'(dac_out), 0);
    check(sample_stb == 1'b0, "R1 strobe after reset", int'(sample_stb), 0);
    measure(ones);
    check(ones == 0, "R1 idle output low", ones, 0);

    send_good(8'hA5, "R2 R8 first byte density");
    send_good(8'h3C, "R3 density 0x3C");
    send_good(8'h01, "R3 density 0x01 lsb first");
    send_good(8'h80, "R3 density 0x80 msb");
    send_good(8'h00, "R4 zero sample silent");
    send_good(8'hFF, "R4 full-scale sample");
    send_good(8'h5A, "R7 replace value");

    s0 = strobes;
    send_frame(8'h11, 1'b0);
    check(strobes == s0, "R5 no strobe on framing error", strobes, s0);
    measure(ones);
    check(ones == 8'h5A, "R5 sample kept after framing error", ones, 8'h5A);

    s0 = strobes;
    @(negedge clk) rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    check(strobes == s0, "R6 no strobe on glitch", strobes, s0);
    measure(ones);
    check(ones == 8'h5A, "R6 sample kept after glitch", ones, 8'h5A);

    send_good(8'hC3, "R7 byte after rejected frames");
    check(exp_q.size() == 0, "R2 all bytes received", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule